// File: doc/BRIEF.md
# Bus Cycle Break Condition Matcher

This block sits beside a processor bus and inspects every bus cycle that carries a valid strobe. Software programs a six-bit condition word, a compare address and an address mask through a small register port. When a cycle satisfies every programmed condition, the block raises a sticky break request. The conditions are the kind of cycle (instruction fetch or data access), its direction (read or write), its operand size, and the address on the bits the mask does not exclude. The request stays raised until a clear pulse arrives.

In each two-bit condition field, code 0 blocks breaks altogether. The size field is the exception: there, code 0 means size is not checked. An instruction fetch is always treated as a word-sized cycle, whatever the width of the physical fetch. A data cycle is classified by the operand size it reports, not by the width of the memory region it reaches.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset, `brk_flag` is 0 and the condition word, compare address and mask all read back as 0. Because the condition word is 0, no break can occur.
- R2: Register index 0 holds the condition word in bits [5:0], and bits above 5 read as 0. Index 1 holds the compare address and index 2 holds the mask. Each reads back exactly as written. Index 3 reads as 0.
- R3: The cycle-kind field is condition bits [5:4]. Code 00 never breaks, 01 allows fetch cycles only (`bus_fetch`=1), 10 allows data cycles only (`bus_fetch`=0), and 11 allows both.
- R4: The direction field is condition bits [3:2]. Code 00 never breaks, 01 allows reads only (`bus_write`=0), 10 allows writes only (`bus_write`=1), and 11 allows both.
- R5: The size field is condition bits [1:0]. Code 00 ignores size. Codes 01, 10 and 11 require a byte, word or longword cycle respectively, where `bus_size` uses 01=byte, 10=word and 11=longword. A data cycle with `bus_size`=00 matches only when size is ignored.
- R6: A fetch cycle is classed as word-sized whatever `bus_size` shows. With size code 01 or 11, a fetch can therefore never match.
- R7: The address condition holds when `bus_addr` equals the compare address on every bit where the mask bit is 0. Bits where the mask bit is 1 are not compared.
- R8: A matching valid cycle sets `brk_flag` on the next rising clock edge. Once set, the flag stays set while `brk_clr` is low.
- R9: `brk_clr` high clears the flag on the next edge. If a match occurs in the same cycle as the clear, the flag is left set.
- R10: Cycles with `bus_valid` low never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| brk_clr | input | 1 | Clear the break flag |
| brk_flag | output | 1 | Sticky break request |

## Verification
The bench tries all 64 condition words against every combination of fetch/data, read/write and the four size codes, with the address held equal to the compare value. The result of each combination is predicted arithmetically from the field encodings. This sweep tells the cycle-kind, direction and size decodes apart from one another. It also separates the forced-word handling of fetches from data cycles with the same reported size. Separate address patterns flip single unmasked bits and single masked bits, which shows that the mask excludes only its own bit positions. Clear pulses are applied with and without a coinciding match, and idle cycles are driven with strobes that would otherwise match.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
   localparam int COND_W = 6;
   localparam int IDX_W  = 2;

   typedef enum logic [1:0] {
      SZ_NONE = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_WORD = 2'b10,
      SZ_LONG = 2'b11
   } size_e;

   localparam logic [IDX_W-1:0] IDX_COND = 2'd0;
   localparam logic [IDX_W-1:0] IDX_CMP  = 2'd1;
   localparam logic [IDX_W-1:0] IDX_MASK = 2'd2;

   typedef struct packed {
      logic [1:0] kind;
      logic [1:0] dir;
      logic [1:0] size;
   } cond_t;
endpackage

// File: rtl/bbm_regs.sv
module bbm_regs
   import bbm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rdata,
   output cond_t             cond,
   output logic [ADDR_W-1:0] cmp,
   output logic [ADDR_W-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond <= '0;
         cmp  <= '0;
         mask <= '0;
      end else if (we) begin
         unique case (idx)
            IDX_COND: cond <= cond_t'(wdata[COND_W-1:0]);
            IDX_CMP:  cmp  <= wdata;
            IDX_MASK: mask <= wdata;
            default:  ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      unique case (idx)
         IDX_COND: rdata[COND_W-1:0] = cond;
         IDX_CMP:  rdata = cmp;
         IDX_MASK: rdata = mask;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/bbm_match.sv
module bbm_match
   import bbm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  cond_t             cond,
   input  logic [ADDR_W-1:0] cmp,
   input  logic [ADDR_W-1:0] mask,
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic              fetch,
   input  logic              write,
   input  logic [1:0]        size,
   output logic              hit
);
   logic [ADDR_W-1:0] miss_bit;
   logic kind_ok, dir_ok, size_ok, addr_ok;
   size_e eff_size;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      assign miss_bit[b] = (addr[b] ^ cmp[b]) & ~mask[b];
   end

   always_comb begin
      eff_size = fetch ? SZ_WORD : size_e'(size);
      kind_ok  = fetch ? cond.kind[0] : cond.kind[1];
      dir_ok   = write ? cond.dir[1]  : cond.dir[0];
      size_ok  = (cond.size == SZ_NONE) || (cond.size == eff_size);
      addr_ok  = ~|miss_bit;
      hit      = valid & kind_ok & dir_ok & size_ok & addr_ok;
   end
endmodule

// File: rtl/bbm_flag.sv
module bbm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/bus_break_matcher.sv
module bus_break_matcher
   import bbm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_idx,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              bus_valid,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_fetch,
   input  logic              bus_write,
   input  logic [1:0]        bus_size,
   input  logic              brk_clr,
   output logic              brk_flag
);
   initial begin
      if (ADDR_W < COND_W || ADDR_W > 64)
         $error("bus_break_matcher: ADDR_W must lie in [%0d,64]", COND_W);
   end

   cond_t             cond_q;
   logic [ADDR_W-1:0] cmp_q;
   logic [ADDR_W-1:0] mask_q;
   logic              hit;

   bbm_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .cond(cond_q), .cmp(cmp_q), .mask(mask_q)
   );

   bbm_match #(.ADDR_W(ADDR_W)) u_match (
      .cond(cond_q), .cmp(cmp_q), .mask(mask_q),
      .valid(bus_valid), .addr(bus_addr), .fetch(bus_fetch),
      .write(bus_write), .size(bus_size), .hit(hit)
   );

   bbm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(brk_clr), .flag(brk_flag)
   );
endmodule

// File: rtl/bbm_chk.sv
module bbm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_valid,
   input logic       bus_fetch,
   input logic       brk_clr,
   input logic       brk_flag,
   input logic [5:0] cond
);
   // R8: a set flag holds while no clear is applied
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_flag && !brk_clr) |=> brk_flag);
   // R9: clear with no cycle present drops the flag
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_clr && !bus_valid) |=> !brk_flag);
   // R10: idle cycles never raise the flag
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid && !brk_flag) |=> !brk_flag);
   // R3: kind code 00 blocks all breaks
   p_nokind_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[5:4] == 2'b00 && !brk_flag) |=> !brk_flag);
   // R4: direction code 00 blocks all breaks
   p_nodir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[3:2] == 2'b00 && !brk_flag) |=> !brk_flag);
   // R6: fetch-only with odd size code can never hit
   p_fetch_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cond[5:4] == 2'b01 && cond[0] && !brk_flag) |=> !brk_flag);
endmodule

bind bus_break_matcher bbm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
   .brk_clr(brk_clr), .brk_flag(brk_flag), .cond(cond_q)
);

// File: tb/bus_break_matcher_tb.sv
module bus_break_matcher_tb;
   localparam int AW = 32;
   logic clk = 0, rst_n = 0;
   logic reg_we = 0;
   logic [1:0] reg_idx = 0;
   logic [AW-1:0] reg_wdata = 0, reg_rdata;
   logic bus_valid = 0, bus_fetch = 0, bus_write = 0, brk_clr = 0, brk_flag;
   logic [AW-1:0] bus_addr = 0;
   logic [1:0] bus_size = 0;
   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   bus_break_matcher #(.ADDR_W(AW)) u_dut (.*);

   task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] i, logic [AW-1:0] d);
      @(negedge clk); reg_we = 1; reg_idx = i; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   function automatic bit model(logic [5:0] c, bit f, bit w, logic [1:0] s);
      logic [1:0] es;
      bit k, d;
      es = f ? 2'b10 : s;
      k = f ? c[4] : c[5];
      d = w ? c[3] : c[2];
      return k && d && (c[1:0] == 2'b00 || c[1:0] == es);
   endfunction

   // one bus cycle, then check flag, then clear
   task automatic cyc(string req, logic [AW-1:0] a, bit f, bit w, logic [1:0] s, bit exp);
      @(negedge clk);
      bus_valid = 1; bus_addr = a; bus_fetch = f; bus_write = w; bus_size = s;
      @(negedge clk);
      bus_valid = 0;
      chk(req, brk_flag, exp);
      brk_clr = 1;
      @(negedge clk);
      brk_clr = 0;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 flag", brk_flag, 0);
      for (int i = 0; i < 3; i++) begin
         reg_idx = 2'(i); #1; chk("R1 regs", reg_rdata, 0);
      end
      // R2 readback
      wr(0, 32'hFFFF_FFED); reg_idx = 0; #1; chk("R2 cond", reg_rdata, 32'h2D);
      wr(1, 32'h1234_5678); reg_idx = 1; #1; chk("R2 cmp", reg_rdata, 32'h1234_5678);
      wr(2, 32'h0000_00F0); reg_idx = 2; #1; chk("R2 mask", reg_rdata, 32'hF0);
      wr(3, 32'hDEAD_BEEF); reg_idx = 3; #1; chk("R2 idx3", reg_rdata, 0);
      wr(2, 0);
      // R3 R4 R5 R6 sweep
      for (int c = 0; c < 64; c++) begin
         wr(0, AW'(c));
         for (int f = 0; f < 2; f++)
            for (int w = 0; w < 2; w++)
               for (int s = 0; s < 4; s++)
                  cyc("R3/R4/R5/R6 sweep", 32'h1234_5678, f[0], w[0], 2'(s),
                      model(6'(c), f[0], w[0], 2'(s)));
      end
      // R7 mask
      wr(0, 32'h3C);  // both kinds, both dirs, size ignored
      wr(2, 32'h0000_FF00);
      for (int b = 0; b < AW; b++) begin
         cyc("R7 bitflip", 32'h1234_5678 ^ (32'h1 << b), 0, 0, 2'b01,
             (b >= 8 && b < 16));
      end
      cyc("R7 equal", 32'h1234_5678, 1, 1, 2'b11, 1);
      // R10 idle strobe
      @(negedge clk); bus_addr = 32'h1234_5678; bus_valid = 0;
      @(negedge clk); chk("R10 idle", brk_flag, 0);
      // R8 sticky
      @(negedge clk); bus_valid = 1;
      @(negedge clk); bus_valid = 0; chk("R8 set", brk_flag, 1);
      repeat (3) @(negedge clk);
      chk("R8 held", brk_flag, 1);
      // R9 clear plus match keeps flag
      bus_valid = 1; brk_clr = 1;
      @(negedge clk); bus_valid = 0; chk("R9 clr+hit", brk_flag, 1);
      @(negedge clk); brk_clr = 0; chk("R9 cleared", brk_flag, 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule